// File: doc/BRIEF.md
# Byte-Enabled 64-bit Parallel CRC-32 Engine

This block computes the reflected CRC-32 (polynomial 0xEDB88320 in reflected form, register preset to all ones, result complemented) over a frame that arrives as a stream of 64-bit beats. Every beat carries an 8-bit lane mask. Frames of any byte length are handled by one 64-bit-per-cycle XOR network. There are no narrower engines for the tail.

The frame's odd bytes are placed in the first beat, in its upper lanes. The unused lower lanes are forced to zero and are processed ahead of the message. Leading zeros would normally disturb a CRC whose register starts at all ones. To prevent this, the register is loaded with a seed for the first beat. The seed is the all-ones preset wound backwards through as many zero bytes as there are empty lanes, so the register reaches the true preset just as the first message byte enters. A fixed complement then produces the final value.

The result and a one-cycle strobe are registered and appear on the cycle after the end-of-frame beat. Frame realignment and MAC framing are done upstream.

Top module: `crc64_frame_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it, `crc_valid_o` is 0 and `crc_o` is 0x00000000.
- R2: The result equals the standard CRC-32 of the frame bytes. The engine uses reflected polynomial 0xEDB88320, preset 0xFFFFFFFF and output complement 0xFFFFFFFF. Bytes are taken in ascending lane order within a beat (lane n is `data_i[8n+7:8n]`) and in arrival order across beats. The nine ASCII bytes "123456789" give 0xCBF43926.
- R3: Bit n of `lanes_i` marks lane n as valid. Only the start-of-frame beat may be partial, and its valid lanes form one contiguous run that ends at lane 7. Every later beat has all 8 lanes valid. Any frame length from 1 byte upward yields the correct CRC.
- R4: Lanes not marked valid in the start-of-frame beat have no effect on the result, whatever data they carry.
- R5: `crc_valid_o` is 1 for exactly one cycle, on the cycle after a beat with both `valid_i` and `eof_i` high. At all other times it is 0. `crc_o` changes only on that cycle and holds its value until the next result.
- R6: Cycles with `valid_i` low change nothing, whatever `sof_i`, `eof_i`, `lanes_i` and `data_i` carry. Idle cycles inside a frame do not change its CRC.
- R7: A start-of-frame beat discards any earlier accumulation, including an unfinished frame. A new frame may begin on the cycle right after an end-of-frame beat.
- R8: A beat with `sof_i` and `eof_i` both high is a complete frame. If its mask is 0x00, the frame is empty and the result is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Beat present this cycle |
| sof_i | input | 1 | Beat is the first of a frame |
| eof_i | input | 1 | Beat is the last of a frame |
| lanes_i | input | 8 | Per-lane valid mask, bit n for lane n |
| data_i | input | 64 | Beat data, lane n in bits 8n+7..8n |
| crc_o | output | 32 | Final CRC of the last completed frame |
| crc_valid_o | output | 1 | One-cycle strobe marking a new `crc_o` |

## Verification
The assertions assume that upstream realignment has already been done. On a start-of-frame beat, the empty lanes are the lowest ones and the valid lanes form one run up to lane 7. On any other valid beat, all lanes are set. The stimulus builds every frame from its length alone. The remainder of the length modulo 8 (or 8 when it divides evenly) sets the first-beat mask as a run of upper bits, and every later beat gets 0xFF. Garbage goes only into the masked-off lower lanes and into idle cycles, and those cycles may raise the frame markers while `valid_i` is low.

// File: rtl/crc64_pkg.sv
package crc64_pkg;
  localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC32_PRESET    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC32_XOROUT    = 32'hFFFF_FFFF;
endpackage

// File: rtl/crc_lane_gate.sv
module crc_lane_gate #(
  parameter int BYTES = 8
) (
  input  logic [BYTES-1:0]   lane_en_i,
  input  logic [8*BYTES-1:0] data_i,
  output logic [8*BYTES-1:0] data_o
);
  for (genvar n = 0; n < BYTES; n++) begin : g_lane
    assign data_o[8*n +: 8] = lane_en_i[n] ? data_i[8*n +: 8] : 8'h00;
  end
endmodule

// File: rtl/crc_pad_seed.sv
module crc_pad_seed #(
  parameter int              BYTES  = 8,
  parameter int              CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0] PRESET = 32'hFFFF_FFFF
) (
  input  logic [BYTES-1:0] lane_en_i,
  output logic [CRC_W-1:0] seed_o
);
  localparam int PAD_W = $clog2(BYTES + 1);

  // Undo nbits zero-input shifts of the reflected register. The top bit of a
  // forward result shows whether the feedback term was applied.
  function automatic logic [CRC_W-1:0] rewind(input logic [CRC_W-1:0] v, input int nbits);
    logic [CRC_W-1:0] r;
    r = v;
    for (int i = 0; i < nbits; i++) begin
      if (r[CRC_W-1]) r = ((r ^ POLY) << 1) | {{(CRC_W-1){1'b0}}, 1'b1};
      else            r = r << 1;
    end
    return r;
  endfunction

  logic [CRC_W-1:0] seed_tab [BYTES+1];
  logic [PAD_W-1:0] pad_cnt;

  for (genvar k = 0; k <= BYTES; k++) begin : g_seed
    localparam logic [CRC_W-1:0] SEED_K = rewind(PRESET, 8 * k);
    assign seed_tab[k] = SEED_K;
  end

  always_comb begin
    pad_cnt = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (!lane_en_i[i]) pad_cnt = pad_cnt + 1'b1;
    end
  end

  assign seed_o = seed_tab[pad_cnt];
endmodule

// File: rtl/crc_xor_net.sv
module crc_xor_net #(
  parameter int               DATA_W = 64,
  parameter int               CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY   = 32'hEDB8_8320
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // Unrolled bit-serial reflected update; collapses into one XOR layer per output bit.
  always_comb begin
    logic [CRC_W-1:0] r;
    logic             fb;
    r = crc_i;
    for (int i = 0; i < DATA_W; i++) begin
      fb = r[0] ^ data_i[i];
      r  = r >> 1;
      if (fb) r = r ^ POLY;
    end
    crc_o = r;
  end
endmodule

// File: rtl/crc64_frame_engine.sv
module crc64_frame_engine
  import crc64_pkg::*;
#(
  parameter int               DATA_W = 64,
  parameter int               CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY   = CRC32_POLY_REFL,
  parameter logic [CRC_W-1:0] PRESET = CRC32_PRESET,
  parameter logic [CRC_W-1:0] XOROUT = CRC32_XOROUT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic                 sof_i,
  input  logic                 eof_i,
  input  logic [DATA_W/8-1:0]  lanes_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [CRC_W-1:0]     crc_o,
  output logic                 crc_valid_o
);
  localparam int BYTES = DATA_W / 8;

  logic [CRC_W-1:0]  acc_q;
  logic [CRC_W-1:0]  seed;
  logic [CRC_W-1:0]  crc_in;
  logic [CRC_W-1:0]  crc_next;
  logic [DATA_W-1:0] data_gated;

  crc_pad_seed #(
    .BYTES (BYTES),
    .CRC_W (CRC_W),
    .POLY  (POLY),
    .PRESET(PRESET)
  ) i_seed (
    .lane_en_i(lanes_i),
    .seed_o   (seed)
  );

  crc_lane_gate #(
    .BYTES(BYTES)
  ) i_gate (
    .lane_en_i(lanes_i),
    .data_i   (data_i),
    .data_o   (data_gated)
  );

  assign crc_in = sof_i ? seed : acc_q;

  crc_xor_net #(
    .DATA_W(DATA_W),
    .CRC_W (CRC_W),
    .POLY  (POLY)
  ) i_net (
    .crc_i (crc_in),
    .data_i(data_gated),
    .crc_o (crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= PRESET;
      crc_o       <= '0;
      crc_valid_o <= 1'b0;
    end else begin
      crc_valid_o <= valid_i && eof_i;
      if (valid_i) begin
        acc_q <= crc_next;
        if (eof_i) crc_o <= crc_next ^ XOROUT;
      end
    end
  end

  // Input-shape checks: the empty lanes of a first beat are the lowest ones.
  logic [BYTES-1:0] empty_lanes;
  logic [BYTES-1:0] empty_plus1;
  logic             first_mask_ok;
  always_comb begin
    empty_lanes   = ~lanes_i;
    empty_plus1   = empty_lanes + 1'b1;
    first_mask_ok = (empty_lanes & empty_plus1) == '0;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!crc_valid_o && crc_o == '0)); // R1
  AST_FIRST_MASK_UPPER: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sof_i) |-> first_mask_ok); // R3
  AST_LATER_MASK_FULL: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !sof_i) |-> (&lanes_i)); // R3
  AST_STROBE_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    (valid_i && eof_i) |=> crc_valid_o); // R5
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(valid_i && eof_i) |=> !crc_valid_o); // R5
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(valid_i && eof_i) |=> $stable(crc_o)); // R6
  AST_EMPTY_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sof_i && eof_i && lanes_i == '0) |=> (crc_o == '0)); // R8
endmodule

// File: tb/test_crc64_frame_engine.sv
`timescale 1ns/1ps
module test_crc64_frame_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i, sof_i, eof_i;
  logic [7:0]  lanes_i;
  logic [63:0] data_i;
  logic [31:0] crc_o;
  logic        crc_valid_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  msg [256];
  logic [31:0] rng = 32'h1234_5678;
  logic        pending = 1'b0;
  logic [31:0] pend_exp;
  string       pend_tag;
  logic [31:0] last_crc = 32'h0;

  always #2 clk = ~clk;

  crc64_frame_engine i_crc64_frame_engine (
    .clk(clk), .rst(rst), .valid_i(valid_i), .sof_i(sof_i), .eof_i(eof_i),
    .lanes_i(lanes_i), .data_i(data_i), .crc_o(crc_o), .crc_valid_o(crc_valid_o)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] ref_crc(input int len);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'h0, msg[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock slot: check what the previous edge produced, then drive the next beat.
  task automatic drive_beat(input logic v, input logic s, input logic e,
                            input logic [7:0] m, input logic [63:0] d,
                            input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (pending) begin
      chk({tag_or(pend_tag), " strobe R5"}, {31'h0, crc_valid_o}, 32'h1);
      chk(pend_tag, crc_o, pend_exp);
      last_crc = pend_exp;
      pending  = 1'b0;
    end else begin
      chk("R5 no strobe", {31'h0, crc_valid_o}, 32'h0);
      chk("R6 result held", crc_o, last_crc);
    end
    valid_i = v; sof_i = s; eof_i = e; lanes_i = m; data_i = d;
    if (v && e) begin
      pending  = 1'b1;
      pend_exp = exp;
      pend_tag = tag;
    end
  endtask

  function automatic string tag_or(input string t);
    return t;
  endfunction

  task automatic idle_beat();
    rng = next_rand(rng);
    // Frame markers raised while valid is low must be ignored (R6).
    drive_beat(1'b0, rng[0], rng[1], rng[15:8], {rng, ~rng}, 32'h0, "R6 idle");
  endtask

  task automatic send_frame(input int len, input bit gaps, input string tag);
    int f, nbeats, base;
    logic [7:0]  m;
    logic [63:0] d;
    logic [31:0] exp;
    exp    = ref_crc(len);
    f      = (len == 0) ? 0 : (((len % 8) == 0) ? 8 : (len % 8));
    nbeats = (len == 0) ? 1 : 1 + (len - f) / 8;
    for (int b = 0; b < nbeats; b++) begin
      rng = next_rand(rng);
      d   = {rng, next_rand(rng)};
      if (b == 0) begin
        m = (f == 0) ? 8'h00 : 8'(8'hFF << (8 - f));
        for (int n = 0; n < 8; n++)
          if (n >= 8 - f) d[8*n +: 8] = msg[n - (8 - f)];
      end else begin
        m    = 8'hFF;
        base = f + 8 * (b - 1);
        for (int n = 0; n < 8; n++) d[8*n +: 8] = msg[base + n];
      end
      drive_beat(1'b1, b == 0, b == nbeats - 1, m, d, exp, tag);
      if (gaps && b != nbeats - 1) idle_beat();
    end
  endtask

  task automatic fill_msg(input int len);
    for (int i = 0; i < len; i++) begin
      rng = next_rand(rng);
      msg[i] = rng[7:0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; lanes_i = 8'h0; data_i = 64'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 strobe in reset", {31'h0, crc_valid_o}, 32'h0);
    chk("R1 crc in reset", crc_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobe after reset", {31'h0, crc_valid_o}, 32'h0);
    chk("R1 crc after reset", crc_o, 32'h0);

    // R2 known vector: "123456789" gives 0xCBF43926 (1 byte in lane 7, then 8 full lanes).
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    chk("R2 bench model", ref_crc(9), 32'hCBF4_3926);
    send_frame(9, 1'b0, "R2 check vector");
    idle_beat();

    // R8 empty single-beat frame, then single-beat frames of every short length.
    send_frame(0, 1'b0, "R8 empty frame");
    idle_beat();
    for (int len = 1; len <= 8; len++) begin
      fill_msg(len);
      send_frame(len, 1'b0, "R8 single beat");
    end
    idle_beat();

    // R3/R4 length sweep with garbage in the empty lanes; R6 gaps on every third length;
    // R7 back-to-back on odd lengths.
    for (int len = 9; len <= 80; len++) begin
      fill_msg(len);
      send_frame(len, (len % 3) == 0, (len % 3) == 0 ? "R6 gapped frame" : "R3 R4 length sweep");
      if ((len % 2) == 0) idle_beat();
    end

    // R7 an unfinished frame is discarded by the next start-of-frame beat.
    rng = next_rand(rng);
    drive_beat(1'b1, 1'b1, 1'b0, 8'hF0, {rng, rng}, 32'h0, "R7 aborted");
    drive_beat(1'b1, 1'b0, 1'b0, 8'hFF, {~rng, rng}, 32'h0, "R7 aborted");
    fill_msg(21);
    send_frame(21, 1'b0, "R7 restart after abort");
    fill_msg(200);
    send_frame(200, 1'b1, "R3 long frame");
    idle_beat();
    idle_beat();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule